// File: doc/BRIEF.md
# Interleaved I/Q Pair Assembler

This block accepts a single parallel bus on which in-phase (I) and quadrature (Q) samples alternate, one word per clock. It pairs them again and presents both words together, in two's-complement form, to a baseband processing chain. A free-running phase toggle sets which half of the pair is on the bus. The block drives a data-clock pin from that toggle, so the source can line its words up with it.

A transmit-enable pin gates the data. While transmit is off, the incoming words are ignored. The outputs are then either forced to zero or kept at the last complete pair. Configuration inputs set the following:

- the pairing order;
- the data-clock polarity;
- the transmit-enable polarity;
- the input number coding;
- the idle behaviour;
- whether the data-clock pin is driven.

The order and polarity settings are taken at pair boundaries only, so a pair is never split across two settings.

Top module: `iq_pair_assembler`

## Requirements
- R1: A synchronous active-low reset clears `i_out`, `q_out` and `pair_vld` to 0, and returns the phase toggle to the first-word slot. The first word after reset release is therefore the first word of a pair. During reset, with default settings, `dclk_out` is 0.
- R2: With `cfg_q_first`=0, the first word of a pair goes to `i_out` and the second to `q_out`. Both appear, together with a `pair_vld` pulse, in the cycle after the second word is captured.
- R3: With `cfg_q_first`=1, the first word of a pair goes to `q_out` and the second to `i_out`.
- R4: With `cfg_clk_inv`=0, `dclk_out` is 1 while a Q word is on the bus and 0 while an I word is on it. With `cfg_clk_inv`=1 these two levels are swapped.
- R5: With `cfg_dclk_en`=0, `dclk_out` is held at 0 while pairing continues unchanged. The enable takes effect in the same cycle.
- R6: With `cfg_tx_inv`=0, `tx_en_pin`=1 means transmit. With `cfg_tx_inv`=1, `tx_en_pin`=0 means transmit.
- R7: While transmit is inactive and `cfg_hold_last`=0, input words are ignored. No `pair_vld` is produced, and `i_out` and `q_out` read 0 from the cycle after the first inactive word.
- R8: While transmit is inactive and `cfg_hold_last`=1, input words are ignored and `i_out`/`q_out` keep the last complete pair.
- R9: With `cfg_offset_bin`=1, the most significant bit of each input word is inverted before output. For example, 0x00000 becomes 0x20000 and 0x3FFFF becomes 0x1FFFF. With `cfg_offset_bin`=0, words pass through unchanged.
- R10: A pair is delivered only if transmit is active for both of its words. A pair with either word inactive is dropped without a `pair_vld` pulse.
- R11: A change of `cfg_q_first`, `cfg_clk_inv` or `cfg_tx_inv` made while the first word of a pair is on the bus does not affect that pair. It applies from the next pair.
- R12: `pair_vld` is a one-cycle pulse, produced exactly once for each delivered pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus word per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 18 | Interleaved I/Q input word |
| tx_en_pin | input | 1 | Transmit enable, polarity per `cfg_tx_inv` |
| cfg_q_first | input | 1 | 1: Q word leads each pair |
| cfg_clk_inv | input | 1 | 1: invert data-clock polarity |
| cfg_tx_inv | input | 1 | 1: transmit when `tx_en_pin` is 0 |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| cfg_hold_last | input | 1 | 1: keep last pair while idle; 0: output zeros |
| cfg_dclk_en | input | 1 | 0: hold `dclk_out` low |
| dclk_out | output | 1 | Data clock marking the I or Q half of the pair |
| i_out | output | 18 | In-phase word, two's complement |
| q_out | output | 18 | Quadrature word, two's complement |
| pair_vld | output | 1 | One-cycle strobe: a new pair is on `i_out`/`q_out` |

## Verification
The bench builds the block with its default 18-bit word width. This puts the sign-bit corner words 0x00000, 0x1FFFF, 0x20000 and 0x3FFFF within reach in both number codings. Every change of order and polarity is made while a pair is half delivered, so the pair-boundary rule is tested alongside the order and clock-level checks. Idle stretches in both idle modes, half-active pairs and a reset in mid-pair check that partial pairs never leak out and that pairing restarts cleanly.

// File: rtl/iqa_pkg.sv
// Shared types for the interleaved I/Q pair assembler.
// Assumes: nothing beyond the parameters of the modules that import it.
package iqa_pkg;

    // Default width of one bus word.
    localparam int unsigned IQA_DEF_W = 18;

    // Settings that may only change at a pair boundary.
    typedef struct packed {
        logic q_first;
        logic clk_inv;
        logic tx_inv;
    } iqa_pair_cfg_t;

endpackage

// File: rtl/iqa_phase_ctrl.sv
// Phase toggle, pair-boundary settings latch, transmit qualifier and
// data-clock pin driver.
// Assumes: one bus word per clock; phase 0 is the first word of a pair.
module iqa_phase_ctrl
    import iqa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_q_first,
    input  logic cfg_clk_inv,
    input  logic cfg_tx_inv,
    input  logic cfg_dclk_en,
    input  logic tx_en_pin,
    output logic phase,
    output logic q_first_act,
    output logic tx_active,
    output logic dclk_out
);

    iqa_pair_cfg_t act_q;
    iqa_pair_cfg_t cfg_in;
    logic          dclk_level;

    // Gather the raw setting inputs into one word.
    always_comb begin
        cfg_in.q_first = cfg_q_first;
        cfg_in.clk_inv = cfg_clk_inv;
        cfg_in.tx_inv  = cfg_tx_inv;
    end

    // Toggle the slot every cycle; load settings as the second word is captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            act_q <= cfg_in;
        end else begin
            phase <= ~phase;
            if (phase) begin
                act_q <= cfg_in;
            end
        end
    end

    // Qualify transmit, and derive the clock level: high while Q is on the bus.
    always_comb begin
        q_first_act = act_q.q_first;
        tx_active   = tx_en_pin ^ act_q.tx_inv;
        dclk_level  = phase ^ act_q.q_first ^ act_q.clk_inv;
        dclk_out    = cfg_dclk_en & dclk_level;
    end

    // R11: settings stay frozen while the second word of a pair is on the bus
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> $stable(act_q));

endmodule

// File: rtl/iqa_word_fmt.sv
// Converts one bus word to two's complement.
// Assumes: offset-binary words differ from two's complement only in the MSB.
module iqa_word_fmt #(
    parameter int unsigned W = iqa_pkg::IQA_DEF_W
) (
    input  logic [W-1:0] word_in,
    input  logic         offset_bin,
    output logic [W-1:0] word_tc
);

    localparam int unsigned MSB = W - 1;

    generate
        if (W > 1) begin : g_wide
            // Invert the sign position only; lower bits pass through.
            assign word_tc = {word_in[MSB] ^ offset_bin, word_in[MSB-1:0]};
        end else begin : g_single
            // A one-bit word is its own sign bit.
            assign word_tc = word_in ^ offset_bin;
        end
    endgenerate

endmodule

// File: rtl/iqa_pair_reg.sv
// Stages the first word of each pair and updates the I/Q output registers
// when the second word arrives; applies the idle policy.
// Assumes: phase comes from iqa_phase_ctrl; words are already two's complement.
module iqa_pair_reg #(
    parameter int unsigned W = iqa_pkg::IQA_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase,
    input  logic         q_first_act,
    input  logic         tx_active,
    input  logic         hold_last,
    input  logic [W-1:0] word_tc,
    output logic [W-1:0] i_out,
    output logic [W-1:0] q_out,
    output logic         pair_vld
);

    logic [W-1:0] stage_q;
    logic         first_ok_q;
    logic         pair_done;

    // A pair completes on a second-slot word that is active, after an active first word.
    assign pair_done = phase & tx_active & first_ok_q;

    // Capture the first word, then deliver the pair or apply the idle policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q    <= '0;
            first_ok_q <= 1'b0;
            i_out      <= '0;
            q_out      <= '0;
            pair_vld   <= 1'b0;
        end else begin
            pair_vld <= 1'b0;
            if (!phase) begin
                stage_q    <= word_tc;
                first_ok_q <= tx_active;
            end
            if (pair_done) begin
                pair_vld <= 1'b1;
                if (q_first_act) begin
                    q_out <= stage_q;
                    i_out <= word_tc;
                end else begin
                    i_out <= stage_q;
                    q_out <= word_tc;
                end
            end else if (!tx_active && !hold_last) begin
                i_out <= '0;
                q_out <= '0;
            end
        end
    end

    // R7: an idle word with zeroing selected clears both outputs
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !hold_last) |=> (i_out == '0 && q_out == '0));

    // R8: an idle word with holding selected leaves both outputs untouched
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && hold_last) |=> ($stable(i_out) && $stable(q_out)));

    // R10: a strobe follows an active second-slot word
    p_vld_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> ($past(tx_active) && $past(phase)));

    // R2: a strobe always lands on a first-slot cycle
    p_vld_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> !phase);

endmodule

// File: rtl/iq_pair_assembler.sv
// Top: rebuilds aligned I/Q pairs from an interleaved parallel bus.
// Assumes: one word per clock, the source aligned to dclk_out, and a
// synchronous active-low reset.
module iq_pair_assembler #(
    parameter int unsigned DATA_W = iqa_pkg::IQA_DEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              tx_en_pin,
    input  logic              cfg_q_first,
    input  logic              cfg_clk_inv,
    input  logic              cfg_tx_inv,
    input  logic              cfg_offset_bin,
    input  logic              cfg_hold_last,
    input  logic              cfg_dclk_en,
    output logic              dclk_out,
    output logic [DATA_W-1:0] i_out,
    output logic [DATA_W-1:0] q_out,
    output logic              pair_vld
);

    logic              phase;
    logic              q_first_act;
    logic              tx_active;
    logic [DATA_W-1:0] word_tc;

    iqa_phase_ctrl u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_q_first (cfg_q_first),
        .cfg_clk_inv (cfg_clk_inv),
        .cfg_tx_inv  (cfg_tx_inv),
        .cfg_dclk_en (cfg_dclk_en),
        .tx_en_pin   (tx_en_pin),
        .phase       (phase),
        .q_first_act (q_first_act),
        .tx_active   (tx_active),
        .dclk_out    (dclk_out)
    );

    iqa_word_fmt #(.W(DATA_W)) u_fmt (
        .word_in    (din),
        .offset_bin (cfg_offset_bin),
        .word_tc    (word_tc)
    );

    iqa_pair_reg #(.W(DATA_W)) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .q_first_act (q_first_act),
        .tx_active   (tx_active),
        .hold_last   (cfg_hold_last),
        .word_tc     (word_tc),
        .i_out       (i_out),
        .q_out       (q_out),
        .pair_vld    (pair_vld)
    );

    // R12: the pair strobe never lasts two cycles
    p_vld_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !pair_vld);

endmodule

// File: tb/iq_pair_assembler_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pairs, the monitor checks them on each strobe.
module iq_pair_assembler_tb_top;

    localparam int W = 18;

    typedef struct packed {
        logic [W-1:0] i;
        logic [W-1:0] q;
    } pair_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         tx_en_pin = 1'b1;
    logic         cfg_q_first = 1'b0;
    logic         cfg_clk_inv = 1'b0;
    logic         cfg_tx_inv = 1'b0;
    logic         cfg_offset_bin = 1'b0;
    logic         cfg_hold_last = 1'b0;
    logic         cfg_dclk_en = 1'b1;
    logic         dclk_out;
    logic [W-1:0] i_out;
    logic [W-1:0] q_out;
    logic         pair_vld;

    int    checks = 0;
    int    failures = 0;
    int    pushed = 0;
    int    strobes = 0;
    bit    done = 1'b0;
    logic  prev_vld = 1'b0;
    pair_t exp_q[$];

    always #4 clk = ~clk;

    iq_pair_assembler #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .tx_en_pin(tx_en_pin),
        .cfg_q_first(cfg_q_first), .cfg_clk_inv(cfg_clk_inv),
        .cfg_tx_inv(cfg_tx_inv), .cfg_offset_bin(cfg_offset_bin),
        .cfg_hold_last(cfg_hold_last), .cfg_dclk_en(cfg_dclk_en),
        .dclk_out(dclk_out), .i_out(i_out), .q_out(q_out), .pair_vld(pair_vld)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] conv(input logic [W-1:0] w, input logic ob);
        return {w[W-1] ^ ob, w[W-2:0]};
    endfunction

    task automatic drive_word(input logic [W-1:0] w, input logic tx);
        din = w;
        tx_en_pin = tx;
        @(negedge clk);
    endtask

    // Drive one pair; optionally queue the expected result and check the clock levels.
    task automatic send_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic t1, input logic t2, input logic push,
                             input logic [W-1:0] ei, input logic [W-1:0] eq,
                             input logic d1, input logic d2);
        pair_t p;
        if (push) begin
            p.i = ei;
            p.q = eq;
            exp_q.push_back(p);
            pushed++;
        end
        chk("R4 dclk first slot", W'(dclk_out), W'(d1));
        drive_word(a, t1);
        chk("R4 dclk second slot", W'(dclk_out), W'(d2));
        drive_word(b, t2);
    endtask

    // Monitor: compare each strobe with the queue head and watch the pulse width.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pair_vld) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R10 actual=unexpected strobe i=%h q=%h expected=none", i_out, q_out);
                end else begin
                    pair_t p;
                    p = exp_q.pop_front();
                    chk("R2/R3 i_out", i_out, p.i);
                    chk("R2/R3 q_out", q_out, p.q);
                end
            end
            if (prev_vld && pair_vld) begin
                checks++;
                failures++;
                $display("FAIL R12 actual=strobe held 2 cycles expected=1 cycle");
            end
        end
        prev_vld = pair_vld;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 i_out", i_out, '0);
        chk("R1 q_out", q_out, '0);
        chk("R1 pair_vld", W'(pair_vld), '0);
        chk("R1 dclk_out", W'(dclk_out), '0);
        rst_n = 1'b1;

        // R2: default I-first order, sign-bit corner words
        send_pair(18'h12345, 18'h00ABC, 1, 1, 1, 18'h12345, 18'h00ABC, 0, 1);
        send_pair(18'h3FFFF, 18'h20000, 1, 1, 1, 18'h3FFFF, 18'h20000, 0, 1);

        // R11 + R3: request Q-first mid-stream; the current pair keeps the old order
        cfg_q_first = 1'b1;
        send_pair(18'h00111, 18'h00222, 1, 1, 1, 18'h00111, 18'h00222, 0, 1);
        send_pair(18'h00333, 18'h00444, 1, 1, 1, 18'h00444, 18'h00333, 1, 0);

        // R4 + R11: clock invert applies from the next pair
        cfg_clk_inv = 1'b1;
        send_pair(18'h00555, 18'h00666, 1, 1, 1, 18'h00666, 18'h00555, 1, 0);
        send_pair(18'h00777, 18'h00888, 1, 1, 1, 18'h00888, 18'h00777, 0, 1);
        cfg_q_first = 1'b0;
        send_pair(18'h00999, 18'h00AAA, 1, 1, 1, 18'h00AAA, 18'h00999, 0, 1);
        send_pair(18'h00BBB, 18'h00CCC, 1, 1, 1, 18'h00BBB, 18'h00CCC, 1, 0);
        cfg_clk_inv = 1'b0;
        send_pair(18'h00DDD, 18'h00EEE, 1, 1, 1, 18'h00DDD, 18'h00EEE, 1, 0);

        // R5: pin held low, data still paired
        cfg_dclk_en = 1'b0;
        send_pair(18'h01234, 18'h05678, 1, 1, 1, 18'h01234, 18'h05678, 0, 0);
        cfg_dclk_en = 1'b1;
        send_pair(18'h0ABCD, 18'h0BCDE, 1, 1, 1, 18'h0ABCD, 18'h0BCDE, 0, 1);

        // R9: offset-binary conversion at the sign boundaries
        cfg_offset_bin = 1'b1;
        send_pair(18'h00000, 18'h3FFFF, 1, 1, 1, conv(18'h00000, 1), conv(18'h3FFFF, 1), 0, 1);
        send_pair(18'h20000, 18'h1FFFF, 1, 1, 1, 18'h00000, 18'h3FFFF, 0, 1);
        cfg_offset_bin = 1'b0;

        // R7: idle with zeroing; the driven data must not appear
        send_pair(18'h15555, 18'h2AAAA, 0, 0, 0, '0, '0, 0, 1);
        chk("R7 i_out zeroed", i_out, '0);
        chk("R7 q_out zeroed", q_out, '0);

        // R8: idle with hold keeps the last pair
        send_pair(18'h0F0F0, 18'h30303, 1, 1, 1, 18'h0F0F0, 18'h30303, 0, 1);
        cfg_hold_last = 1'b1;
        send_pair(18'h11111, 18'h22222, 0, 0, 0, '0, '0, 0, 1);
        chk("R8 i_out held", i_out, 18'h0F0F0);
        chk("R8 q_out held", q_out, 18'h30303);

        // R10: half-active pairs are dropped
        send_pair(18'h01010, 18'h02020, 1, 0, 0, '0, '0, 0, 1);
        send_pair(18'h03030, 18'h04040, 0, 1, 0, '0, '0, 0, 1);
        chk("R10 i_out unchanged", i_out, 18'h0F0F0);
        chk("R10 q_out unchanged", q_out, 18'h30303);

        // R6 + R11: inverted transmit polarity from the next pair
        cfg_tx_inv = 1'b1;
        send_pair(18'h06060, 18'h07070, 1, 1, 1, 18'h06060, 18'h07070, 0, 1);
        send_pair(18'h08080, 18'h09090, 0, 0, 1, 18'h08080, 18'h09090, 0, 1);
        send_pair(18'h0A0A0, 18'h0B0B0, 1, 1, 0, '0, '0, 0, 1);
        chk("R6 standby holds i", i_out, 18'h08080);
        chk("R6 standby holds q", q_out, 18'h09090);
        cfg_hold_last = 1'b0;
        send_pair(18'h0C0C0, 18'h0D0D0, 1, 1, 0, '0, '0, 0, 1);
        chk("R6 standby zeroes i", i_out, '0);
        cfg_tx_inv = 1'b0;
        send_pair(18'h0E0E0, 18'h0F0F1, 0, 0, 1, 18'h0E0E0, 18'h0F0F1, 0, 1);
        send_pair(18'h10101, 18'h20202, 1, 1, 1, 18'h10101, 18'h20202, 0, 1);

        // R1: reset in mid-pair restarts pairing
        drive_word(18'h33333, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 i_out after mid reset", i_out, '0);
        chk("R1 q_out after mid reset", q_out, '0);
        chk("R1 vld after mid reset", W'(pair_vld), '0);
        rst_n = 1'b1;
        send_pair(18'h00ACE, 18'h00BDF, 1, 1, 1, 18'h00ACE, 18'h00BDF, 0, 1);
        drive_word('0, 0);
        drive_word('0, 0);

        // R12: one strobe per delivered pair
        chk("R12 strobes vs pairs", W'(strobes), W'(pushed));
        chk("R12 queue drained", W'(exp_q.size()), '0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule